// File: doc/BRIEF.md
# Register List Stack Frame Sequencer

This block runs the two multi-cycle frame instructions of a small processor core. A frame build saves a chosen subset of the upper twelve general registers, r20 through r31, to the stack and then reserves local space. A frame release gives the local space back, reloads the chosen registers from the stack and can end with an indirect jump through any general register. Bit i of the 12-bit register list stands for register r(20+i).

The core hands over one command with a single-cycle start pulse: the list, a 5-bit count of local words, a 5-bit jump register number and the direction (build or release). The sequencer then owns a 32-bit word memory port with a request/acknowledge handshake and a register-file port with a combinational read and a registered write. It keeps the stack pointer itself; the pointer leaves reset at a parameter value. Completion is a one-cycle pulse, issued in the same cycle as the last pointer update or jump.

Top module: `stack_frame_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle: busy_o, done_o, mem_req_o, rf_we_o and pc_we_o are 0 and sp_o equals the SP_INIT parameter (default 32'h0000_0800).
- R2: A build (op_release_i = 0) walks list bits from 0 up to 11. For each set bit i it first lowers the stack pointer by 4, then writes register r(20+i) as one word (mem_we_o = 1) at the lowered pointer. The lowest-numbered register therefore ends up at the highest address.
- R3: After its last store, a build lowers the stack pointer by frame_words_i × 4. That update is the final one, and done_o pulses in that cycle.
- R4: A release (op_release_i = 1) first raises the stack pointer by frame_words_i × 4. It then walks list bits from 11 down to 0. For each set bit i it reads one word (mem_we_o = 0) at the current pointer, writes it to register r(20+i), and raises the pointer by 4.
- R5: After the reloads of a release, a nonzero jump_reg_i makes pc_we_o pulse with pc_o equal to that register's value, as seen after the reloads. A zero field causes no pc_we_o pulse. A build never pulses pc_we_o.
- R6: A memory request keeps mem_addr_o, mem_we_o and mem_wdata_o stable until mem_ack_i arrives. The next list position is handled only after that acknowledge.
- R7: An empty list makes no memory transfer and no register write; only the frame-size adjustment is applied.
- R8: A start pulse that arrives while busy_o is 1 is ignored: the running command's traffic, stack pointer and done pulse are unchanged.
- R9: Each command gives exactly one single-cycle done_o pulse, and busy_o is 0 afterwards.
- R10: Only registers whose list bit is set are transferred, one memory transfer per set bit. Register-file writes only target r20 to r31, and memory request, register write and PC write never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle command start, honoured only when idle |
| op_release_i | input | 1 | 0 = build frame, 1 = release frame |
| reg_mask_i | input | 12 | Bit i selects register r(20+i) |
| frame_words_i | input | 5 | Local space in 4-byte words |
| jump_reg_i | input | 5 | Release only: register holding the jump target, 0 = no jump |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Transfer complete |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 32 | Register-file write data |
| pc_we_o | output | 1 | Jump strobe |
| pc_o | output | 32 | Jump target |
| sp_o | output | 32 | Current stack pointer |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A corrupted list register or scan direction shows at the memory port as a wrong address in the transfer log. This appears with the first misplaced transfer of the command, and it becomes a wrong saved or reloaded register value once the command ends. A wrong stack pointer step shows in sp_o right after the next done pulse. Because each command starts from the pointer left by the one before, the error also shifts every later address. A broken idle guard or done logic shows as an extra transfer, a missing or doubled done pulse, or a PC strobe where none is expected. All of these surface within the same command.

// File: rtl/stack_frame_pkg.sv
package stack_frame_pkg;

  typedef enum logic [1:0] {
    SP_HOLD,
    SP_ADD,
    SP_SUB
  } sp_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_ISSUE,
    ST_WAIT,
    ST_JRD
  } seq_state_e;

endpackage

// File: rtl/fs_bit_pick.sv
module fs_bit_pick #(
  parameter int NREGS = 12,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] mask_i,
  input  logic             descend_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  // descend_i = 0 selects the lowest set bit, 1 the highest
  always_comb begin
    found_o = |mask_i;
    idx_o   = '0;
    if (descend_i) begin
      for (int k = 0; k < NREGS; k++)
        if (mask_i[k]) idx_o = IDX_W'(k);
    end else begin
      for (int k = NREGS - 1; k >= 0; k--)
        if (mask_i[k]) idx_o = IDX_W'(k);
    end
  end

endmodule

// File: rtl/fs_sp_unit.sv
module fs_sp_unit
  import stack_frame_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [31:0] SP_INIT = 32'h0000_0800
) (
  input  logic          clk,
  input  logic          rst,
  input  sp_op_e        op_i,
  input  logic [DW-1:0] amt_i,
  output logic [DW-1:0] sp_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_o <= DW'(SP_INIT);
    end else begin
      case (op_i)
        SP_ADD:  sp_o <= sp_o + amt_i;
        SP_SUB:  sp_o <= sp_o - amt_i;
        default: sp_o <= sp_o;
      endcase
    end
  end

endmodule

// File: rtl/fs_mem_port.sv
module fs_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mem_ack_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          xfer_done_o
);

  assign xfer_done_o = mem_req_o & mem_ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else if (issue_i && !mem_req_o) begin
      mem_req_o   <= 1'b1;
      mem_we_o    <= we_i;
      mem_addr_o  <= addr_i;
      mem_wdata_o <= wdata_i;
    end else if (xfer_done_o) begin
      mem_req_o <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o))); // R6

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import stack_frame_pkg::*;
#(
  parameter int          NREGS    = 12,
  parameter int          REG_BASE = 20,
  parameter int          RA_W     = 5,
  parameter int          SZ_W     = 5,
  parameter int          DW       = 32,
  parameter logic [31:0] SP_INIT  = 32'h0000_0800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             op_release_i,
  input  logic [NREGS-1:0] reg_mask_i,
  input  logic [SZ_W-1:0]  frame_words_i,
  input  logic [RA_W-1:0]  jump_reg_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [DW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_ack_i,
  output logic [RA_W-1:0]  rf_raddr_o,
  input  logic [DW-1:0]    rf_rdata_i,
  output logic             rf_we_o,
  output logic [RA_W-1:0]  rf_waddr_o,
  output logic [DW-1:0]    rf_wdata_o,
  output logic             pc_we_o,
  output logic [DW-1:0]    pc_o,
  output logic [DW-1:0]    sp_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int          IDX_W     = $clog2(NREGS);
  localparam int          WORD_B    = 4;
  localparam logic [DW-1:0] WORD_STEP = DW'(WORD_B);

  seq_state_e           state_q;
  logic [NREGS-1:0]     mask_q;
  logic                 release_q;
  logic [SZ_W-1:0]      size_q;
  logic [RA_W-1:0]      jreg_q;
  logic [IDX_W-1:0]     idx_q;

  logic                 pick_found;
  logic [IDX_W-1:0]     pick_idx;
  sp_op_e               sp_op;
  logic [DW-1:0]        sp_amt;
  logic [DW-1:0]        sp_w;
  logic                 issue;
  logic                 issue_we;
  logic [DW-1:0]        issue_addr;
  logic                 xfer_done;

  function automatic logic [DW-1:0] frame_bytes(input logic [SZ_W-1:0] words);
    return DW'({words, 2'b00});
  endfunction

  function automatic logic [RA_W-1:0] list_reg(input logic [IDX_W-1:0] idx);
    return RA_W'(REG_BASE) + RA_W'(idx);
  endfunction

  fs_bit_pick #(.NREGS(NREGS)) u_pick (
    .mask_i    (mask_q),
    .descend_i (release_q),
    .found_o   (pick_found),
    .idx_o     (pick_idx)
  );

  fs_sp_unit #(.DW(DW), .SP_INIT(SP_INIT)) u_sp (
    .clk   (clk),
    .rst   (rst),
    .op_i  (sp_op),
    .amt_i (sp_amt),
    .sp_o  (sp_w)
  );

  fs_mem_port #(.AW(DW), .DW(DW)) u_mem (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue),
    .we_i        (issue_we),
    .addr_i      (issue_addr),
    .wdata_i     (rf_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .xfer_done_o (xfer_done)
  );

  assign sp_o   = sp_w;
  assign busy_o = (state_q != ST_IDLE);

  // Stack pointer steps and memory issue, decoded from the sequencer state
  always_comb begin
    sp_op      = SP_HOLD;
    sp_amt     = WORD_STEP;
    issue      = 1'b0;
    issue_we   = !release_q;
    issue_addr = release_q ? sp_w : (sp_w - WORD_STEP);
    case (state_q)
      ST_IDLE: begin
        if (start_i && op_release_i) begin
          sp_op  = SP_ADD;
          sp_amt = frame_bytes(frame_words_i);
        end
      end
      ST_PICK: begin
        if (!pick_found && !release_q) begin
          sp_op  = SP_SUB;
          sp_amt = frame_bytes(size_q);
        end
      end
      ST_ISSUE: begin
        issue = 1'b1;
        if (!release_q) sp_op = SP_SUB;
      end
      ST_WAIT: begin
        if (xfer_done && release_q) sp_op = SP_ADD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mask_q     <= '0;
      release_q  <= 1'b0;
      size_q     <= '0;
      jreg_q     <= '0;
      idx_q      <= '0;
      rf_raddr_o <= '0;
      rf_we_o    <= 1'b0;
      rf_waddr_o <= '0;
      rf_wdata_o <= '0;
      pc_we_o    <= 1'b0;
      pc_o       <= '0;
      done_o     <= 1'b0;
    end else begin
      rf_we_o <= 1'b0;
      pc_we_o <= 1'b0;
      done_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mask_q    <= reg_mask_i;
            release_q <= op_release_i;
            size_q    <= frame_words_i;
            jreg_q    <= jump_reg_i;
            state_q   <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (pick_found) begin
            idx_q      <= pick_idx;
            rf_raddr_o <= list_reg(pick_idx);
            state_q    <= ST_ISSUE;
          end else if (!release_q) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (jreg_q != '0) begin
            rf_raddr_o <= jreg_q;
            state_q    <= ST_JRD;
          end else begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_ISSUE: begin
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (xfer_done) begin
            mask_q[idx_q] <= 1'b0;
            if (release_q) begin
              rf_we_o    <= 1'b1;
              rf_waddr_o <= list_reg(idx_q);
              rf_wdata_o <= mem_rdata_i;
            end
            state_q <= ST_PICK;
          end
        end
        ST_JRD: begin
          pc_o    <= rf_rdata_i;
          pc_we_o <= 1'b1;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_STORE_AT_SP: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req_o) && mem_we_o) |-> (mem_addr_o == sp_w)); // R2

  AST_RELOAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_ack_i && !mem_we_o) |=> (sp_w == $past(sp_w) + WORD_STEP)); // R4

  AST_RELOAD_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && release_q) |-> !mem_we_o); // R4

  AST_PC_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    pc_we_o |-> (done_o && release_q && jreg_q != '0)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy_o) |-> (!mem_req_o && !rf_we_o)); // R8

  AST_RF_RANGE: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_waddr_o >= RA_W'(REG_BASE))); // R10

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req_o, rf_we_o, pc_we_o})); // R10

endmodule

// File: tb/test_stack_frame_seq.sv
module test_stack_frame_seq;

  localparam logic [31:0] SP0 = 32'h0000_0800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        op_release_i = 1'b0;
  logic [11:0] reg_mask_i = '0;
  logic [4:0]  frame_words_i = '0;
  logic [4:0]  jump_reg_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ack_i = 1'b0;
  logic [4:0]  rf_raddr_o;
  logic [31:0] rf_rdata_i;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        pc_we_o;
  logic [31:0] pc_o, sp_o;
  logic        busy_o, done_o;

  stack_frame_seq i_stack_frame_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .op_release_i(op_release_i),
    .reg_mask_i(reg_mask_i), .frame_words_i(frame_words_i), .jump_reg_i(jump_reg_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .pc_we_o(pc_we_o),
    .pc_o(pc_o), .sp_o(sp_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] bmem [0:1023];
  logic [31:0] regs [0:31];
  logic [31:0] log_addr [0:15];
  logic        log_we   [0:15];
  int          log_n;
  int          done_cnt;
  int          pc_cnt;
  logic [31:0] pc_seen;
  int          wait_cnt = 0;
  logic [31:0] exp_sp;
  int          cycles = 0;
  bit          wd_fired = 0;

  assign rf_rdata_i = regs[rf_raddr_o];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory and register-file models plus port monitors, all on the falling edge
  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (wait_cnt == 0) begin
        if (mem_we_o) bmem[mem_addr_o[11:2]] = mem_wdata_o;
        else          mem_rdata_i = bmem[mem_addr_o[11:2]];
        if (log_n < 16) begin
          log_addr[log_n] = mem_addr_o;
          log_we[log_n]   = mem_we_o;
        end
        log_n++;
        mem_ack_i = 1'b1;
        wait_cnt  = int'($urandom_range(0, 3));
      end else begin
        wait_cnt--;
      end
    end
    if (rf_we_o) regs[rf_waddr_o] = rf_wdata_o;
    if (done_o) done_cnt++;
    if (pc_we_o) begin
      pc_cnt++;
      pc_seen = pc_o;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !wd_fired) begin
      wd_fired = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_op(input bit rel, input logic [11:0] mask, input logic [4:0] size,
                        input logic [4:0] jreg, input bit inject);
    logic [31:0] a;
    logic [31:0] exp_addr [0:15];
    logic [31:0] exp_regs [0:31];
    logic [31:0] sp_start;
    int          n_exp = 0;
    int          guard = 0;
    sp_start = exp_sp;
    for (int r = 0; r < 32; r++) exp_regs[r] = regs[r];
    if (!rel) begin
      a = sp_start;
      for (int i = 0; i < 12; i++)
        if (mask[i]) begin
          a = a - 32'd4;
          exp_addr[n_exp] = a;
          n_exp++;
        end
      exp_sp = a - {25'd0, size, 2'b00};
    end else begin
      a = sp_start + {25'd0, size, 2'b00};
      for (int i = 11; i >= 0; i--)
        if (mask[i]) begin
          exp_addr[n_exp] = a;
          exp_regs[20 + i] = bmem[a[11:2]];
          n_exp++;
          a = a + 32'd4;
        end
      exp_sp = a;
    end
    log_n = 0; done_cnt = 0; pc_cnt = 0; pc_seen = '0;
    @(negedge clk);
    start_i = 1'b1; op_release_i = rel; reg_mask_i = mask;
    frame_words_i = size; jump_reg_i = jreg;
    @(negedge clk);
    start_i = 1'b0;
    if (inject) begin
      @(negedge clk);
      chk(busy_o == 1'b1, "R8 busy during command", {31'd0, busy_o}, 32'd1);
      start_i = 1'b1; op_release_i = !rel; reg_mask_i = ~mask;
      frame_words_i = ~size; jump_reg_i = 5'd7;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
    chk(!busy_o, "R9 idle after done", {31'd0, busy_o}, 0);
    chk(sp_o == exp_sp, rel ? "R4 sp after release" : "R3 sp after build", sp_o, exp_sp);
    chk(log_n == n_exp, mask == 0 ? "R7 no transfer for empty list" : "R10 transfer count",
        log_n, n_exp);
    for (int k = 0; k < n_exp && k < 16 && k < log_n; k++) begin
      chk(log_addr[k] == exp_addr[k], rel ? "R4 reload address order" : "R2 store address order",
          log_addr[k], exp_addr[k]);
      chk(log_we[k] == !rel, "R10 transfer direction", {31'd0, log_we[k]}, {31'd0, !rel});
    end
    if (!rel) begin
      a = sp_start;
      for (int i = 0; i < 12; i++)
        if (mask[i]) begin
          a = a - 32'd4;
          chk(bmem[a[11:2]] == regs[20 + i], "R2 stored value", bmem[a[11:2]], regs[20 + i]);
        end
      chk(pc_cnt == 0, "R5 no jump on build", pc_cnt, 0);
    end else begin
      for (int r = 0; r < 32; r++)
        if (regs[r] !== exp_regs[r])
          chk(1'b0, "R4 reloaded register", regs[r], exp_regs[r]);
      chk(1'b1, "R4 register file", 0, 0);
      if (jreg != 0) begin
        chk(pc_cnt == 1, "R5 jump strobe", pc_cnt, 1);
        chk(pc_seen == exp_regs[jreg], "R5 jump target", pc_seen, exp_regs[jreg]);
      end else begin
        chk(pc_cnt == 0, "R5 no jump for zero field", pc_cnt, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int w = 0; w < 1024; w++) bmem[w] = $urandom;
    regs[0] = '0;
    for (int r = 1; r < 32; r++) regs[r] = $urandom;
    exp_sp = SP0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sp_o == SP0, "R1 reset sp", sp_o, SP0);
    chk(!busy_o && !done_o, "R1 reset idle", {30'd0, busy_o, done_o}, 0);
    chk(!mem_req_o && !rf_we_o && !pc_we_o, "R1 reset strobes",
        {29'd0, mem_req_o, rf_we_o, pc_we_o}, 0);

    // Directed corner cases
    run_op(1'b0, 12'h000, 5'd7,  5'd0,  1'b0);  // R7 empty build
    run_op(1'b1, 12'h000, 5'd7,  5'd0,  1'b0);  // R7 empty release
    run_op(1'b0, 12'hFFF, 5'd0,  5'd0,  1'b0);  // R2 full list
    run_op(1'b1, 12'hFFF, 5'd0,  5'd25, 1'b0);  // R5 jump via reloaded register
    run_op(1'b0, 12'h801, 5'd31, 5'd0,  1'b0);  // R3 largest frame
    run_op(1'b1, 12'h801, 5'd31, 5'd3,  1'b0);  // R5 jump via r3
    run_op(1'b0, 12'h5A5, 5'd4,  5'd0,  1'b1);  // R8 start while busy
    run_op(1'b1, 12'h5A5, 5'd4,  5'd0,  1'b1);  // R8 start while busy

    // Constrained random commands
    for (int t = 0; t < 60; t++) begin
      bit rel;
      logic [4:0] jr;
      rel = $urandom_range(0, 1) == 1;
      if (exp_sp < 32'h200) rel = 1'b1;
      if (exp_sp > 32'hD00) rel = 1'b0;
      jr = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
      run_op(rel, 12'($urandom), 5'($urandom), jr, 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule